// File: doc/BRIEF.md
# Folded four-tap FIR filter

This block filters a stream of signed samples with a four-tap finite impulse response, using one multiplier and one accumulator for all taps. It accepts one sample per transaction and then walks the taps one per clock. During that walk each history entry moves one place along the delay line, and the new sample goes into the line only on the last step. A short controller with three states (waiting, stepping through taps, publishing) sequences the walk.

The coefficients come from a register bank outside the block and arrive as one packed vector. The block keeps the sample history itself from one transaction to the next. The caller presents a sample with a valid strobe while the busy flag is low. It then waits for the one-cycle result strobe. The result has the full width of the accumulator and is neither rounded nor saturated.

Top module: `fold_fir`

## Requirements
- R1: A synchronous active-high `rst` drives `busy`, `out_valid` and `out_data` to zero and empties the sample history, so the first result after reset equals the new sample times c[0].
- R2: A sample is taken on a rising clock edge where `in_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle on.
- R3: After an accepting edge, `busy` stays at 1 for exactly TAPS+1 cycles (five with four taps). In the following cycle `busy` is 0 and `out_valid` is 1 for that one cycle only. A new sample may be offered in that same cycle.
- R4: The result equals c[0]*x[n] + c[1]*x[n-1] + c[2]*x[n-2] + c[3]*x[n-3]. All values are signed two's complement. x[n-k] is the sample accepted k transactions earlier, and zero if none was accepted since reset. Coefficient c[i] sits in bits [i*COEF_W +: COEF_W] of `coef`.
- R5: An `in_valid` that arrives while `busy` is 1 is ignored. It does not change the result in progress and adds no entry to the history.
- R6: `out_data` is DATA_W+COEF_W+log2(TAPS) bits wide and carries the exact sum, even when every sample and coefficient is at its most negative value.
- R7: `out_data` holds the last result until the next `out_valid` cycle. It does not change while a new sample is being processed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Offers `in_sample` for filtering |
| in_sample | input | DATA_W | Signed input sample |
| coef | input | TAPS*COEF_W | Packed signed coefficients, c[i] at bits [i*COEF_W +: COEF_W]; held steady while busy |
| busy | output | 1 | A result is being computed; new samples are ignored |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | DATA_W+COEF_W+log2(TAPS) | Signed filter result, full accumulator width |

## Verification
The bench builds the filter with 4-bit samples and 4-bit coefficients. This makes it possible to sweep all sixteen sample values against several coefficient sets, including sets with mixed signs and zero. At this small width the arithmetic model in the bench covers every operand value. With all operands at -8, the worst-case sum lands inside the 10-bit result, which checks the guard-bit sizing directly. Stray strobes are driven on every busy cycle of half the transactions, and a reset in mid-stream confirms that the history is cleared.

// File: rtl/fold_fir_pkg.sv
package fold_fir_pkg;

    // Controller states: waiting for a sample, stepping through taps, publishing.
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LOOP = 2'd1,
        FS_DONE = 2'd2
    } fir_state_e;

endpackage

// File: rtl/fold_fir_ctrl.sv
module fold_fir_ctrl
    import fold_fir_pkg::*;
#(
    parameter int TAPS  = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             accept,
    output logic             step,
    output logic             finish,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);

    typedef struct packed {
        fir_state_e       st;
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            FS_IDLE: begin
                if (in_valid) begin
                    ctl_d.st  = FS_LOOP;
                    ctl_d.idx = IDX_W'(TAPS - 1);
                end
            end
            FS_LOOP: begin
                if (ctl_q.idx == '0) begin
                    ctl_d.st = FS_DONE;
                end else begin
                    ctl_d.idx = ctl_q.idx - 1'b1;
                end
            end
            FS_DONE: begin
                ctl_d.st = FS_IDLE;
            end
            default: begin
                ctl_d.st = FS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: FS_IDLE, idx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign accept = (ctl_q.st == FS_IDLE) && in_valid;
    assign step   = (ctl_q.st == FS_LOOP);
    assign finish = (ctl_q.st == FS_DONE);
    assign busy   = (ctl_q.st != FS_IDLE);
    assign idx    = ctl_q.idx;

endmodule

// File: rtl/fold_fir_dline.sv
module fold_fir_dline #(
    parameter int TAPS   = 4,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              step,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] in_sample,
    output logic [DATA_W-1:0] tap_val
);

    typedef struct packed {
        logic [TAPS-1:0][DATA_W-1:0] line;
        logic [DATA_W-1:0]           smp;
    } dline_t;

    dline_t dl_d, dl_q;

    // Value each entry takes when its index is visited: the held sample for
    // entry 0, otherwise the neighbour one place nearer the input.
    logic [DATA_W-1:0] src [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_src
        if (k == 0) begin : g_head
            assign src[k] = dl_q.smp;
        end else begin : g_body
            assign src[k] = dl_q.line[k-1];
        end
    end

    always_comb begin
        dl_d = dl_q;
        if (accept) begin
            dl_d.smp = in_sample;
        end
        if (step) begin
            for (int k = 0; k < TAPS; k++) begin
                if (idx == IDX_W'(k)) begin
                    dl_d.line[k] = src[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dl_q <= '0;
        end else begin
            dl_q <= dl_d;
        end
    end

    // The multiplier sees the value the visited entry is being updated to.
    assign tap_val = src[idx];

endmodule

// File: rtl/fold_fir_mac.sv
module fold_fir_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              step,
    input  logic              finish,
    input  logic [DATA_W-1:0] tap_val,
    input  logic [COEF_W-1:0] coef_val,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int GUARD  = ACC_W - PROD_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] res;
        logic             vld;
    } mac_t;

    mac_t mac_d, mac_q;

    logic [PROD_W-1:0] a_ext;
    logic [PROD_W-1:0] b_ext;
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  prod_ext;

    assign a_ext    = {{COEF_W{tap_val[DATA_W-1]}}, tap_val};
    assign b_ext    = {{DATA_W{coef_val[COEF_W-1]}}, coef_val};
    assign prod     = a_ext * b_ext;
    assign prod_ext = {{GUARD{prod[PROD_W-1]}}, prod};

    always_comb begin
        mac_d     = mac_q;
        mac_d.vld = 1'b0;
        if (accept) begin
            mac_d.acc = '0;
        end else if (step) begin
            mac_d.acc = mac_q.acc + prod_ext;
        end
        if (finish) begin
            mac_d.res = mac_q.acc;
            mac_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mac_q <= '0;
        end else begin
            mac_q <= mac_d;
        end
    end

    assign out_valid = mac_q.vld;
    assign out_data  = mac_q.res;

endmodule

// File: rtl/fold_fir.sv
module fold_fir #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int TAPS   = 4
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      in_valid,
    input  logic [DATA_W-1:0]                         in_sample,
    input  logic [TAPS*COEF_W-1:0]                    coef,
    output logic                                      busy,
    output logic                                      out_valid,
    output logic [DATA_W+COEF_W+$clog2(TAPS)-1:0]     out_data
);

    localparam int IDX_W  = $clog2(TAPS);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(TAPS);

    logic             accept;
    logic             step;
    logic             finish;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] tap_val;
    logic [COEF_W-1:0] coef_val;

    fold_fir_ctrl #(
        .TAPS  (TAPS),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .accept   (accept),
        .step     (step),
        .finish   (finish),
        .busy     (busy),
        .idx      (idx)
    );

    fold_fir_dline #(
        .TAPS   (TAPS),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_dline (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .step      (step),
        .idx       (idx),
        .in_sample (in_sample),
        .tap_val   (tap_val)
    );

    // Coefficient for the tap being visited this cycle.
    assign coef_val = coef[idx*COEF_W +: COEF_W];

    fold_fir_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .step      (step),
        .finish    (finish),
        .tap_val   (tap_val),
        .coef_val  (coef_val),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/fold_fir_chk.sv
module fold_fir_chk #(
    parameter int TAPS  = 4,
    parameter int ACC_W = 34
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             busy,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_data
);

    // Length of the most recent busy stretch, counted cycle by cycle.
    logic [7:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 8'd1;
        end else begin
            busy_run <= '0;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!busy && !out_valid && out_data == '0));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy) |=> busy);

    p_busy_span_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (busy_run == 8'(TAPS + 1)));

    p_fall_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> out_valid);

    p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_strobe_idle_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !busy);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

endmodule

bind fold_fir fold_fir_chk #(
    .TAPS  (TAPS),
    .ACC_W (ACC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_fold_fir.sv
module sim_fold_fir;

    localparam int CLK_P = 10;
    localparam int DW    = 4;
    localparam int CW    = 4;
    localparam int NT    = 4;
    localparam int AW    = DW + CW + 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [DW-1:0]   in_sample = '0;
    logic [NT*CW-1:0] coef = '0;
    logic            busy;
    logic            out_valid;
    logic [AW-1:0]   out_data;

    int total = 0;
    int bad = 0;
    int h0 = 0, h1 = 0, h2 = 0;
    int c0 = 0, c1 = 0, c2 = 0, c3 = 0;
    int last_exp = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fold_fir #(
        .DATA_W (DW),
        .COEF_W (CW),
        .TAPS   (NT)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .coef      (coef),
        .busy      (busy),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_coef(input int a0, input int a1, input int a2, input int a3);
        c0 = a0; c1 = a1; c2 = a2; c3 = a3;
        coef = {CW'(a3), CW'(a2), CW'(a1), CW'(a0)};
    endtask

    // Called at a falling edge; returns at the falling edge after the result strobe.
    task automatic send(input int x, input bit noise);
        int exp;
        in_valid  = 1'b1;
        in_sample = DW'(x);
        @(negedge clk);
        in_valid = 1'b0;
        chk(busy == 1'b1, "R2", int'(busy), 1);
        // R7: previous result still present, no strobe
        chk(out_valid == 1'b0 && $signed(out_data) == last_exp, "R7",
            int'($signed(out_data)), last_exp);
        for (int k = 1; k <= NT; k++) begin
            if (noise) begin
                in_valid  = 1'b1;        // R5: stray strobe while busy
                in_sample = DW'(x + 3 * k + 1);
            end
            @(negedge clk);
            chk(busy == 1'b1 && out_valid == 1'b0, "R3", int'(busy), 1);
        end
        in_valid = 1'b0;
        @(negedge clk);
        exp = x * c0 + h0 * c1 + h1 * c2 + h2 * c3;
        chk(out_valid == 1'b1 && busy == 1'b0, "R3", int'(out_valid), 1);
        chk($signed(out_data) == exp, noise ? "R5" : "R4", int'($signed(out_data)), exp);
        h2 = h1; h1 = h0; h0 = x;
        last_exp = exp;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(busy == 1'b0 && out_valid == 1'b0 && out_data == '0, "R1",
            int'(out_data), 0);
        h0 = 0; h1 = 0; h2 = 0;
        last_exp = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        set_coef(1, 2, 3, 4);
        do_reset();
        // R1: empty history gives x*c0 only
        send(3, 1'b0);
        chk($signed(out_data) == 3, "R1", int'($signed(out_data)), 3);

        set_coef(1, 2, 3, 4);
        for (int x = -8; x < 8; x++) send(x, x[0]);
        set_coef(-8, 7, -1, 5);
        for (int x = -8; x < 8; x++) send(x, x[0]);
        set_coef(7, -8, 0, 3);
        for (int x = 7; x >= -8; x--) send(x, ~x[0]);
        set_coef(0, 0, 0, -8);
        for (int x = -8; x < 8; x++) send(x, 1'b1);

        // R6: every operand at its most negative value
        set_coef(-8, -8, -8, -8);
        for (int n = 0; n < 4; n++) send(-8, 1'b0);
        chk($signed(out_data) == 256, "R6", int'($signed(out_data)), 256);

        // R1: reset in mid-stream clears history
        set_coef(1, 2, 3, 4);
        send(6, 1'b0);
        do_reset();
        send(5, 1'b1);
        chk($signed(out_data) == 5, "R1", int'($signed(out_data)), 5);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule